// File: doc/BRIEF.md
# Block-Synchronous Serial Demultiplexer

This block takes in a composite serial stream made of equal-length blocks. The stream arrives one bit per cycle in which `bit_en` is high. Each block opens with an 8-bit label, and the label names either a synchronization block or one of three data sources. The block first gains block alignment. To do so it hunts bit by bit for a marker, which is seven zeros followed by a one, and then checks that the next 24 bits equal the configured sync pattern exactly. A sync block then carries three 8-bit header words (source, destination, format) and a stretch of fill bits. A data block carries 96 payload bits, and the block routes these to the serial output of the source that the label names.

Labels are compared against four configured code words by Hamming distance. A received label within distance 2 of exactly one code word is taken as that word. A label that matches none of them, or that is close to two of them, counts as a loss of alignment and sends the block back to the hunt. Once the block is locked, a sync pattern may contain up to `err_tol` mismatching bits and lock still holds. Every field is sent most significant bit first.

Top module: `blk_demux`

## Requirements
- R1: After reset, `locked` is 0, `out_vld` is all zero and the header outputs are 0.
- R2: While hunting, a one that follows at least seven consecutive zeros starts a comparison of the next 24 bits against `sync_pat`. `locked` rises on the enabled bit that completes an error-free comparison. While unlocked, `out_vld` stays zero.
- R3: During acquisition, a single pattern bit that differs from `sync_pat` aborts the attempt and `locked` stays 0.
- R4: After a sync pattern passes, the next 24 bits are latched MSB first as `hdr_src`, `hdr_dst` and `hdr_fmt`, in that order. Then 48 fill bits are skipped, and the following 8 bits are the next label.
- R5: A label decoded as source k (k = 0..2, code word `lbl_src[8k+7:8k]`) sends each of the next 96 enabled bits to `out_bit[k]`. For each such bit, `out_vld[k]` is high for the one cycle after it, and the other valid lines stay low.
- R6: A sync block decoded while locked keeps lock and updates the header outputs when at most `err_tol` (0..7) of its pattern bits mismatch.
- R7: A received label within Hamming distance 2 of exactly one code word (`lbl_sync` or a source word) decodes to that word.
- R8: A label at distance 3 or more from every code word drives `locked` low and returns to the hunt, and the following bits produce no `out_vld`.
- R9: A label within distance 2 of two code words is treated as undecodable, with the same result as R8.
- R10: A sync pattern received while locked with more than `err_tol` mismatches drives `locked` low and returns to the hunt.
- R11: A cycle with `bit_en` low advances nothing. It raises no `out_vld` and changes neither `locked` nor the header outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial composite data bit |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| lbl_sync | input | 8 | Code word of the sync label |
| lbl_src | input | 24 | Source code words, source k at bits 8k+7:8k |
| sync_pat | input | 24 | Expected sync pattern, MSB received first |
| err_tol | input | 3 | Pattern mismatches tolerated while locked |
| locked | output | 1 | Block alignment held |
| out_bit | output | 3 | Routed payload bit per source |
| out_vld | output | 3 | Per-source strobe for `out_bit` |
| hdr_src | output | 8 | First header word of the last sync block |
| hdr_dst | output | 8 | Second header word |
| hdr_fmt | output | 8 | Third header word |

## Verification
The ambiguous-label case is the hardest to reach from the ports. With four code words 5 apart, no received word can sit within distance 2 of two of them. The bench therefore reprograms one source code word so that it lies at distance 4 from another, and then sends a label halfway between the two. Tolerance at its edge is also driven on purpose. The bench flips exactly `err_tol` pattern bits in one locked sync block and one bit more in the next, and it must relock afterwards through a clean sync block that is found by the zero-run hunt.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_PAT,
    ST_HDR,
    ST_FILL,
    ST_LBL,
    ST_DATA
  } dm_state_t;
endpackage

// File: rtl/dm_label_dec.sv
module dm_label_dec #(
  parameter int LW   = 8,
  parameter int NL   = 4,
  parameter int CORR = 2,
  localparam int IW  = (NL > 1) ? $clog2(NL) : 1,
  localparam int DW  = $clog2(LW + 1)
) (
  input  logic [LW-1:0]    rx,
  input  logic [NL*LW-1:0] words,
  output logic             ok,
  output logic [IW-1:0]    idx
);
  function automatic logic [DW-1:0] popc(input logic [LW-1:0] v);
    logic [DW-1:0] s;
    s = '0;
    for (int b = 0; b < LW; b++) s = s + DW'(v[b]);
    return s;
  endfunction

  logic [NL-1:0] hit;

  for (genvar i = 0; i < NL; i++) begin : g_dist
    assign hit[i] = popc(rx ^ words[i*LW +: LW]) <= DW'(CORR);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NL; i++) begin
      if (hit[i]) idx = IW'(i);
    end
    ok = ($countones(hit) == 1);
  end
endmodule

// File: rtl/dm_router.sv
module dm_router #(
  parameter int N_SRC = 3,
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SW-1:0]    sel,
  input  logic             d,
  output logic [N_SRC-1:0] out_bit,
  output logic [N_SRC-1:0] out_vld
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        out_vld[k] <= 1'b0;
        out_bit[k] <= 1'b0;
      end else begin
        out_vld[k] <= en && (sel == SW'(k));
        if (en && (sel == SW'(k))) out_bit[k] <= d;
      end
    end
  end
endmodule

// File: rtl/dm_ctrl.sv
module dm_ctrl
  import dm_pkg::*;
#(
  parameter int LBL_W   = 8,
  parameter int PAT_W   = 24,
  parameter int HDR_W   = 24,
  parameter int FILL_W  = 48,
  parameter int DATA_W  = 96,
  parameter int TOL_W   = 3,
  parameter int N_SRC   = 3,
  localparam int NL     = N_SRC + 1,
  localparam int IW     = (NL > 1) ? $clog2(NL) : 1,
  localparam int SW     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CNT_W  = $clog2(DATA_W + 1),
  localparam int ZW     = $clog2(LBL_W),
  localparam int PIW    = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_en,
  input  logic [PAT_W-1:0] sync_pat,
  input  logic [TOL_W-1:0] err_tol,
  input  logic             dec_ok,
  input  logic [IW-1:0]    dec_idx,
  output logic [LBL_W-1:0] lbl_word,
  output logic             route_en,
  output logic [SW-1:0]    route_sel,
  output logic             locked,
  output logic [HDR_W-1:0] hdr
);
  dm_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] errs;
  logic [ZW-1:0]    zrun;
  logic             acq;
  logic [HDR_W-2:0] hsr;
  logic [LBL_W-2:0] lsr;
  logic [PIW-1:0]   pat_idx;
  logic             mism;
  logic [CNT_W-1:0] errs_nx;
  logic             pat_bad;

  assign pat_idx  = PIW'(PAT_W - 1) - PIW'(cnt);
  assign mism     = bit_in ^ sync_pat[pat_idx];
  assign errs_nx  = errs + CNT_W'(mism);
  assign pat_bad  = acq ? mism : (errs_nx > CNT_W'(err_tol));
  assign lbl_word = {lsr, bit_in};
  assign route_en = bit_en && (st == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HUNT;
      cnt       <= '0;
      errs      <= '0;
      zrun      <= '0;
      acq       <= 1'b1;
      hsr       <= '0;
      lsr       <= '0;
      hdr       <= '0;
      route_sel <= '0;
      locked    <= 1'b0;
    end else if (bit_en) begin
      case (st)
        ST_HUNT: begin
          if (!bit_in) begin
            if (zrun != ZW'(LBL_W - 1)) zrun <= zrun + 1'b1;
          end else begin
            zrun <= '0;
            if (zrun == ZW'(LBL_W - 1)) begin
              st   <= ST_PAT;
              cnt  <= '0;
              errs <= '0;
              acq  <= 1'b1;
            end
          end
        end
        ST_PAT: begin
          errs <= errs_nx;
          if (pat_bad) begin
            st     <= ST_HUNT;
            zrun   <= '0;
            locked <= 1'b0;
          end else if (cnt == CNT_W'(PAT_W - 1)) begin
            st     <= ST_HDR;
            cnt    <= '0;
            locked <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HDR: begin
          hsr <= {hsr[HDR_W-3:0], bit_in};
          if (cnt == CNT_W'(HDR_W - 1)) begin
            hdr <= {hsr, bit_in};
            st  <= ST_FILL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FILL: begin
          if (cnt == CNT_W'(FILL_W - 1)) begin
            st  <= ST_LBL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LBL: begin
          lsr <= {lsr[LBL_W-3:0], bit_in};
          if (cnt == CNT_W'(LBL_W - 1)) begin
            cnt <= '0;
            if (!dec_ok) begin
              st     <= ST_HUNT;
              zrun   <= '0;
              locked <= 1'b0;
            end else if (dec_idx == '0) begin
              st   <= ST_PAT;
              errs <= '0;
              acq  <= 1'b0;
            end else begin
              st        <= ST_DATA;
              route_sel <= SW'(dec_idx - IW'(1));
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == CNT_W'(DATA_W - 1)) begin
            st  <= ST_LBL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/blk_demux.sv
module blk_demux #(
  parameter int LBL_W   = 8,
  parameter int PAT_W   = 24,
  parameter int WORD_W  = 8,
  parameter int N_WORDS = 3,
  parameter int BLK_W   = 104,
  parameter int N_SRC   = 3,
  parameter int TOL_W   = 3,
  parameter int CORR    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_in,
  input  logic                   bit_en,
  input  logic [LBL_W-1:0]       lbl_sync,
  input  logic [N_SRC*LBL_W-1:0] lbl_src,
  input  logic [PAT_W-1:0]       sync_pat,
  input  logic [TOL_W-1:0]       err_tol,
  output logic                   locked,
  output logic [N_SRC-1:0]       out_bit,
  output logic [N_SRC-1:0]       out_vld,
  output logic [WORD_W-1:0]      hdr_src,
  output logic [WORD_W-1:0]      hdr_dst,
  output logic [WORD_W-1:0]      hdr_fmt
);
  localparam int DATA_W = BLK_W - LBL_W;
  localparam int HDR_W  = N_WORDS * WORD_W;
  localparam int FILL_W = DATA_W - PAT_W - HDR_W;
  localparam int NL     = N_SRC + 1;
  localparam int IW     = (NL > 1) ? $clog2(NL) : 1;
  localparam int SW     = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [LBL_W-1:0] lbl_word;
  logic             dec_ok;
  logic [IW-1:0]    dec_idx;
  logic             route_en;
  logic [SW-1:0]    route_sel;
  logic [HDR_W-1:0] hdr;

  dm_label_dec #(.LW(LBL_W), .NL(NL), .CORR(CORR)) u_dec (
    .rx    (lbl_word),
    .words ({lbl_src, lbl_sync}),
    .ok    (dec_ok),
    .idx   (dec_idx)
  );

  dm_ctrl #(
    .LBL_W(LBL_W), .PAT_W(PAT_W), .HDR_W(HDR_W), .FILL_W(FILL_W),
    .DATA_W(DATA_W), .TOL_W(TOL_W), .N_SRC(N_SRC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .bit_en    (bit_en),
    .sync_pat  (sync_pat),
    .err_tol   (err_tol),
    .dec_ok    (dec_ok),
    .dec_idx   (dec_idx),
    .lbl_word  (lbl_word),
    .route_en  (route_en),
    .route_sel (route_sel),
    .locked    (locked),
    .hdr       (hdr)
  );

  dm_router #(.N_SRC(N_SRC)) u_rt (
    .clk     (clk),
    .rst     (rst),
    .en      (route_en),
    .sel     (route_sel),
    .d       (bit_in),
    .out_bit (out_bit),
    .out_vld (out_vld)
  );

  assign hdr_src = hdr[HDR_W-1 -: WORD_W];
  assign hdr_dst = hdr[HDR_W-WORD_W-1 -: WORD_W];
  assign hdr_fmt = hdr[WORD_W-1:0];
endmodule

// File: rtl/dm_checker.sv
module dm_checker #(
  parameter int N_SRC  = 3,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_in,
  input logic              bit_en,
  input logic              locked,
  input logic [N_SRC-1:0]  out_bit,
  input logic [N_SRC-1:0]  out_vld,
  input logic [WORD_W-1:0] hdr_src
);
  p_vld_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_vld));

  p_bit_follows_r5: assert property (@(posedge clk) disable iff (rst)
    (|out_vld) |-> ((out_bit & out_vld) == ({N_SRC{$past(bit_in)}} & out_vld)));

  p_route_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (|out_vld) |-> locked);

  p_vld_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
    (|out_vld) |-> $past(bit_en));

  p_lock_stall_r11: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(locked));

  p_hdr_stall_r4: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(hdr_src));
endmodule

bind blk_demux dm_checker #(.N_SRC(N_SRC), .WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_in  (bit_in),
  .bit_en  (bit_en),
  .locked  (locked),
  .out_bit (out_bit),
  .out_vld (out_vld),
  .hdr_src (hdr_src)
);

// File: tb/blk_demux_test.sv
module blk_demux_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic        bit_en = 1'b0;
  logic [7:0]  lbl_sync = 8'h01;
  logic [23:0] lbl_src = {8'h1E, 8'hE7, 8'hF8};
  logic [23:0] sync_pat = 24'hB4D2A5;
  logic [2:0]  err_tol = 3'd0;
  logic        locked;
  logic [2:0]  out_bit;
  logic [2:0]  out_vld;
  logic [7:0]  hdr_src, hdr_dst, hdr_fmt;

  int checks = 0;
  int errors = 0;

  localparam logic [95:0] D_A = 96'hA5A5_5A5A_C3C3_3C3C_9696_6969;
  localparam logic [95:0] D_B = 96'h1234_5678_9ABC_DEF0_F00F_1EE1;
  localparam logic [95:0] D_C = 96'hCAFE_F00D_5A5A_A5A5_3C3C_C3C3;

  always #4 clk = ~clk;

  blk_demux uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en),
    .lbl_sync(lbl_sync), .lbl_src(lbl_src), .sync_pat(sync_pat),
    .err_tol(err_tol), .locked(locked), .out_bit(out_bit),
    .out_vld(out_vld), .hdr_src(hdr_src), .hdr_dst(hdr_dst),
    .hdr_fmt(hdr_fmt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_en = 1'b1;
    @(posedge clk);
    #1;
    bit_en = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  // Sync block: label 0x01, pattern xor mask, three header words, 48 fill bits
  task automatic send_sync(input logic [23:0] mask, input logic [7:0] s,
                           input logic [7:0] dd, input logic [7:0] f,
                           input logic exp_lock, input string req);
    send_word(32'(lbl_sync), 8);
    send_word(32'(sync_pat ^ mask), 24);
    check({req, " lock after pattern"}, 32'(locked), 32'(exp_lock));
    send_word({8'h00, s, dd, f}, 24);
    for (int i = 0; i < 48; i++) send_bit((i % 2) == 0);
    if (exp_lock) begin
      check({req, " R4 hdr_src"}, 32'(hdr_src), 32'(s));
      check({req, " R4 hdr_dst"}, 32'(hdr_dst), 32'(dd));
      check({req, " R4 hdr_fmt"}, 32'(hdr_fmt), 32'(f));
    end
  endtask

  // Data block; k < 0 means no routing expected; gap idle cycles after each bit
  task automatic send_data(input logic [7:0] lbl, input logic [95:0] d,
                           input int k, input int gap, input string req);
    int bad;
    logic [2:0] ev;
    bad = 0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(lbl[i]);
      if (out_vld !== 3'b000) bad++;
    end
    ev = (k < 0) ? 3'b000 : 3'(1 << k);
    for (int i = 95; i >= 0; i--) begin
      send_bit(d[i]);
      if (out_vld !== ev) bad++;
      if (k >= 0 && out_bit[k] !== d[i]) bad++;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk);
        #1;
        if (out_vld !== 3'b000) bad++;
      end
    end
    check({req, " mismatching bits"}, 32'(bad), 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 locked", 32'(locked), 32'd0);
    check("R1 out_vld", 32'(out_vld), 32'd0);
    check("R1 hdr_src", 32'(hdr_src), 32'd0);
  endtask

  task automatic t_unlocked;
    send_word(32'hA5A5, 16);
    send_data(8'hF8, D_A, -1, 0, "R2 unlocked data ignored");
    check("R2 still unlocked", 32'(locked), 32'd0);
  endtask

  task automatic t_acq_fail;
    send_sync(24'h000400, 8'h12, 8'h34, 8'h56, 1'b0, "R3 one-bit error");
    send_data(8'hF8, D_A, -1, 0, "R3 after abort");
    check("R3 locked", 32'(locked), 32'd0);
  endtask

  task automatic t_acquire;
    send_sync(24'h0, 8'h12, 8'h34, 8'h56, 1'b1, "R2 clean acquisition");
  endtask

  task automatic t_route;
    send_data(8'hF8, D_A, 0, 0, "R5 source 0");
    send_data(8'hE7, D_B, 1, 0, "R5 source 1");
    send_data(8'h1E, D_C, 2, 0, "R5 source 2");
    check("R5 lock held", 32'(locked), 32'd1);
  endtask

  task automatic t_correct;
    send_data(8'hE7 ^ 8'h81, D_A, 1, 0, "R7 two-bit label error");
    send_data(8'h1E ^ 8'h40, D_B, 2, 0, "R7 one-bit label error");
  endtask

  task automatic t_stall;
    send_data(8'h1E, D_A, 2, 2, "R11 idle gaps");
    check("R11 lock held", 32'(locked), 32'd1);
  endtask

  task automatic t_tolerate;
    err_tol = 3'd3;
    send_sync(24'h800101, 8'h9A, 8'hBC, 8'hDE, 1'b1, "R6 three errors tolerated");
    send_data(8'hF8, D_C, 0, 0, "R6 routing after tolerant sync");
  endtask

  task automatic t_exceed;
    send_sync(24'h810101, 8'h11, 8'h22, 8'h33, 1'b0, "R10 four errors");
    check("R10 hdr unchanged", 32'(hdr_src), 32'h9A);
    send_data(8'hF8, D_A, -1, 0, "R10 after drop");
    err_tol = 3'd0;
    send_sync(24'h0, 8'h21, 8'h43, 8'h65, 1'b1, "R2 relock");
  endtask

  task automatic t_undecodable;
    send_data(8'h55, D_A, -1, 0, "R8 undecodable label");
    check("R8 lock dropped", 32'(locked), 32'd0);
    send_sync(24'h0, 8'h12, 8'h34, 8'h56, 1'b1, "R2 relock");
  endtask

  task automatic t_ambiguous;
    lbl_src[23:16] = 8'hF7;
    send_data(8'hFB, D_B, -1, 0, "R9 ambiguous label");
    check("R9 lock dropped", 32'(locked), 32'd0);
    lbl_src[23:16] = 8'h1E;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_unlocked();
    t_acq_fail();
    t_acquire();
    t_route();
    t_correct();
    t_stall();
    t_tolerate();
    t_exceed();
    t_undecodable();
    t_ambiguous();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule